// File: doc/BRIEF.md
# Branch Trace Packet Decoder

This block turns a byte stream that starts on a branch packet boundary into one decoded record per packet. Each packet has three sections. The address section comes first and is 1 to 5 bytes long. An exception section of 0 to 2 bytes may follow it. A cycle-count section of 1 to 5 bytes follows when cycle-accurate mode is on. Most packets send only the low part of the target address. The block keeps a stored context (last address, alignment state, security bit and alternate-state bit) and fills every bit that was not sent from that context. It updates the context each time a packet completes.

A neighbouring parser recognises synchronization packets and loads a full context through the sync-load port. The decoded record carries the target address, the alignment state, the exception number, the security bit, the alternate-state bit, the hypervisor flag, a branch-executed flag, the cycle count and a count-present flag. If a section runs longer than the format allows, the packet is discarded and a protocol-error pulse is raised.

Top module: `bpd_decoder`

## Requirements
- R1: In an address byte, bit 7 = 1 means another address byte follows and bit 7 = 0 ends the address section. When byte 0 ends the section, no exception bytes follow. Byte 0 carries payload bits [5:0] in bits [6:1]. Bytes 1 to 3 carry 7 payload bits in bits [6:0] when bit 7 = 1, and 6 payload bits in bits [5:0] when they end the section. Byte k (k = 1..3) starts at payload bit 6+7(k-1).
- R2: When one of address bytes 1 to 4 ends the address section, its bit 6 = 1 means exception bytes follow and bit 6 = 0 means none follow.
- R3: A record (rec_valid high for one cycle) appears in the cycle after the last byte of the packet is accepted, and never earlier. Address bits that were not sent take their values from the stored address, which is updated to the record's address at that same edge.
- R4: Address byte 4 has bit 4 = state (1 halfword-aligned, 0 word-aligned). For halfword, bits [3:0] are payload [30:27]; for word, bits [2:0] are payload [29:27]. Without byte 4 the stored state is kept. The payload is placed at address bit 1 (halfword) or bit 2 (word), and the address bits below that are 0.
- R5: Exception byte 0 holds: bit 0 security, bits [4:1] exception[3:0], bit 5 alternate state, bit 7 = 1 a second exception byte follows. Exception byte 1 holds: bits [4:0] exception[8:4], bit 5 hypervisor.
- R6: Without exception bytes, the exception number is 0, the hypervisor flag is 0, and security and alternate state keep their stored values. rec_exec is 1 exactly when the exception number is 0.
- R7: When cycle-accurate mode is 1, sampled on the first address byte, count bytes follow the address and exception sections. Count byte 0 carries count[3:0] in bits [3:0]. Byte k (k = 1..4) carries count bits starting at 4+7(k-1) in bits [6:0]. Bit 7 = 1 means another count byte follows. Bits not sent are 0, and rec_cnt_vld is 1.
- R8: A sixth address byte, a third exception byte or a sixth count byte is flagged by the byte before it having bit 7 = 1. That byte raises proto_err for one cycle (one cycle after it is accepted), produces no record and leaves the context unchanged. The next byte starts a new packet.
- R9: A sync_load pulse loads the address, state, security and alternate-state context. If it comes in the same cycle as a packet's last byte, the record uses the old context and the sync values are stored.
- R10: During reset and in the first cycle after it, in_ready is 0, with no record and no error. After that in_ready is 1. The reset context is address 0, word-aligned state, security 0 and alternate state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte present |
| in_byte | input | 8 | Trace byte |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| cyc_mode | input | 1 | Cycle-accurate mode |
| sync_load | input | 1 | Load context from the sync fields |
| sync_addr | input | 32 | Sync address |
| sync_half | input | 1 | Sync state (1 halfword) |
| sync_ns | input | 1 | Sync security bit |
| sync_alt | input | 1 | Sync alternate-state bit |
| rec_valid | output | 1 | Record strobe |
| rec_addr | output | 32 | Target address |
| rec_half | output | 1 | Target state |
| rec_exc | output | 9 | Exception number |
| rec_ns | output | 1 | Security bit |
| rec_alt | output | 1 | Alternate-state bit |
| rec_hyp | output | 1 | Hypervisor flag |
| rec_exec | output | 1 | Branch executed |
| rec_cnt | output | 32 | Cycle count |
| rec_cnt_vld | output | 1 | Count present |
| proto_err | output | 1 | Overlong section |

## Verification
The two functions that can fall in the same cycle are the context write at packet completion and a sync load. The bench pulses sync_load together with a packet's final byte, in directed cases and at random. It then checks two things: the record must be merged against the old address, and the next compressed packet must merge against the sync address. The bench also toggles cycle-accurate mode in the middle of packets, so that sampling on the first byte is judged on every random packet.

// File: rtl/bpd_pkg.sv
// Shared constants and types for the branch packet decoder.
// Assumes the 32-bit address and count formats described in the brief.
package bpd_pkg;
    parameter int ADDR_W  = 32;
    parameter int CNT_W   = 32;
    parameter int PAY_W   = 31;
    parameter int EXC_W   = 9;
    parameter int IDX_W   = 3;
    parameter int LAST_IX = 4;
    localparam int B0_BITS  = 6;
    localparam int MID_BITS = 7;
    localparam int B4_BASE  = B0_BITS + 3 * MID_BITS;
    localparam int CNT_B0   = 4;

    typedef enum logic [1:0] {SEC_ADDR, SEC_EXC, SEC_CNT} sec_e;

    typedef struct packed {
        logic [PAY_W-1:0] pay;
        logic [PAY_W-1:0] mask;
        logic             b4;
        logic             half;
        logic             exc_on;
        logic [EXC_W-1:0] exc;
        logic             ns;
        logic             alt;
        logic             hyp;
        logic [CNT_W-1:0] cnt;
        logic             cnt_on;
    } pkt_t;
endpackage

// File: rtl/bpd_parser.sv
// Section parser: walks address, exception and count sections byte by byte.
// Presents the collected fields (next-state view) with a done or err strobe
// on the accepting cycle. Assumes the stream starts on a packet boundary.
module bpd_parser
    import bpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic [7:0] byte_in,
    input  logic       cyc_mode,
    output pkt_t       pkt_nx,
    output logic       done,
    output logic       err
);
    sec_e             sec_q, sec_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic             cyc_q, cyc_n;
    pkt_t             acc_q, acc_n;
    logic             fin, follow;
    int               base;

    // Next-state decode of one accepted byte.
    always_comb begin
        sec_n = sec_q; idx_n = idx_q; cyc_n = cyc_q; acc_n = acc_q;
        done = 1'b0; err = 1'b0; fin = 1'b0; follow = 1'b0; base = 0;
        if (take) begin
            case (sec_q)
                SEC_ADDR: begin
                    if (idx_q == '0) begin
                        acc_n = '0;
                        cyc_n = cyc_mode;
                        acc_n.pay[B0_BITS-1:0]  = byte_in[6:1];
                        acc_n.mask[B0_BITS-1:0] = '1;
                        fin = !byte_in[7];
                    end else if (idx_q < IDX_W'(LAST_IX)) begin
                        base = B0_BITS + MID_BITS * (int'(idx_q) - 1);
                        if (byte_in[7]) begin
                            acc_n.pay[base +: MID_BITS]  = byte_in[6:0];
                            acc_n.mask[base +: MID_BITS] = '1;
                        end else begin
                            acc_n.pay[base +: MID_BITS-1]  = byte_in[5:0];
                            acc_n.mask[base +: MID_BITS-1] = '1;
                            fin = 1'b1;
                            follow = byte_in[6];
                        end
                    end else if (byte_in[7]) begin
                        err = 1'b1;
                    end else begin
                        acc_n.b4   = 1'b1;
                        acc_n.half = byte_in[4];
                        acc_n.pay[PAY_W-1:B4_BASE]  = byte_in[4] ? byte_in[3:0] : {1'b0, byte_in[2:0]};
                        acc_n.mask[PAY_W-1:B4_BASE] = '1;
                        fin = 1'b1;
                        follow = byte_in[6];
                    end
                    if (!fin && !err) idx_n = idx_q + 1'b1;
                    if (fin) begin
                        idx_n = '0;
                        if (follow) begin
                            sec_n = SEC_EXC; acc_n.exc_on = 1'b1;
                        end else if (cyc_n) begin
                            sec_n = SEC_CNT; acc_n.cnt_on = 1'b1;
                        end else done = 1'b1;
                    end
                end
                SEC_EXC: begin
                    if (idx_q == '0) begin
                        acc_n.ns = byte_in[0];
                        acc_n.exc[3:0] = byte_in[4:1];
                        acc_n.alt = byte_in[5];
                        fin = !byte_in[7];
                        if (byte_in[7]) idx_n = 1;
                    end else if (byte_in[7]) begin
                        err = 1'b1;
                    end else begin
                        acc_n.exc[EXC_W-1:4] = byte_in[4:0];
                        acc_n.hyp = byte_in[5];
                        fin = 1'b1;
                    end
                    if (fin) begin
                        idx_n = '0;
                        if (cyc_q) begin
                            sec_n = SEC_CNT; acc_n.cnt_on = 1'b1;
                        end else done = 1'b1;
                    end
                end
                default: begin
                    if (idx_q == '0) acc_n.cnt[CNT_B0-1:0] = byte_in[3:0];
                    else begin
                        base = CNT_B0 + MID_BITS * (int'(idx_q) - 1);
                        acc_n.cnt[base +: MID_BITS] = byte_in[6:0];
                    end
                    if (!byte_in[7]) done = 1'b1;
                    else if (idx_q == IDX_W'(LAST_IX)) err = 1'b1;
                    else idx_n = idx_q + 1'b1;
                end
            endcase
            if (done || err) begin
                sec_n = SEC_ADDR; idx_n = '0;
            end
        end
    end

    // Section, index and collection registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= SEC_ADDR; idx_q <= '0; cyc_q <= 1'b0; acc_q <= '0;
        end else begin
            sec_q <= sec_n; idx_q <= idx_n; cyc_q <= cyc_n; acc_q <= acc_n;
        end
    end

    assign pkt_nx = acc_n;

    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_W'(LAST_IX));
    // R5
    exc_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q == SEC_EXC) |-> (idx_q <= 1));
endmodule

// File: rtl/bpd_addr_merge.sv
// Combinational merge of the received payload into the stored address.
// Assumes the payload mask marks exactly the bits that were sent.
module bpd_addr_merge
    import bpd_pkg::*;
(
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              base_half,
    input  pkt_t              pkt,
    output logic [ADDR_W-1:0] addr,
    output logic              half
);
    logic [ADDR_W-1:0] p_w, m_w, p_s, m_s, mix;

    // Shift payload by alignment, replace sent bits, clear sub-alignment bits.
    always_comb begin
        half = pkt.b4 ? pkt.half : base_half;
        p_w  = {{(ADDR_W-PAY_W){1'b0}}, pkt.pay};
        m_w  = {{(ADDR_W-PAY_W){1'b0}}, pkt.mask};
        p_s  = half ? (p_w << 1) : (p_w << 2);
        m_s  = half ? (m_w << 1) : (m_w << 2);
        mix  = (base_addr & ~m_s) | (p_s & m_s);
        mix[0] = 1'b0;
        if (!half) mix[1] = 1'b0;
        addr = mix;
    end
endmodule

// File: rtl/bpd_ctx.sv
// Stored decode context: last address, state, security and alternate bits.
// A sync load outranks a packet update in the same cycle.
module bpd_ctx
    import bpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_half,
    input  logic              upd_flags,
    input  logic              upd_ns,
    input  logic              upd_alt,
    input  logic              sync_load,
    input  logic [ADDR_W-1:0] sync_addr,
    input  logic              sync_half,
    input  logic              sync_ns,
    input  logic              sync_alt,
    output logic [ADDR_W-1:0] ctx_addr,
    output logic              ctx_half,
    output logic              ctx_ns,
    output logic              ctx_alt
);
    // Context register with sync priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_addr <= '0; ctx_half <= 1'b0; ctx_ns <= 1'b0; ctx_alt <= 1'b0;
        end else if (sync_load) begin
            ctx_addr <= sync_addr; ctx_half <= sync_half;
            ctx_ns <= sync_ns; ctx_alt <= sync_alt;
        end else if (upd) begin
            ctx_addr <= upd_addr; ctx_half <= upd_half;
            if (upd_flags) begin
                ctx_ns <= upd_ns; ctx_alt <= upd_alt;
            end
        end
    end

    // R9
    sync_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_load && rst_n) |-> (ctx_addr == $past(sync_addr)));
endmodule

// File: rtl/bpd_decoder.sv
// Top of the branch packet decoder. Accepts one byte per cycle, parses it,
// merges the address against the stored context and registers one record
// per completed packet. Assumes byte alignment to packet starts upstream.
module bpd_decoder
    import bpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    input  logic              cyc_mode,
    input  logic              sync_load,
    input  logic [ADDR_W-1:0] sync_addr,
    input  logic              sync_half,
    input  logic              sync_ns,
    input  logic              sync_alt,
    output logic              rec_valid,
    output logic [ADDR_W-1:0] rec_addr,
    output logic              rec_half,
    output logic [EXC_W-1:0]  rec_exc,
    output logic              rec_ns,
    output logic              rec_alt,
    output logic              rec_hyp,
    output logic              rec_exec,
    output logic [CNT_W-1:0]  rec_cnt,
    output logic              rec_cnt_vld,
    output logic              proto_err
);
    pkt_t              pkt;
    logic              done, err, take;
    logic [ADDR_W-1:0] ctx_addr, m_addr;
    logic              ctx_half, ctx_ns, ctx_alt, m_half;

    assign take = in_valid && in_ready;

    bpd_parser u_parser (
        .clk(clk), .rst_n(rst_n), .take(take), .byte_in(in_byte),
        .cyc_mode(cyc_mode), .pkt_nx(pkt), .done(done), .err(err)
    );

    bpd_addr_merge u_merge (
        .base_addr(ctx_addr), .base_half(ctx_half), .pkt(pkt),
        .addr(m_addr), .half(m_half)
    );

    bpd_ctx u_ctx (
        .clk(clk), .rst_n(rst_n), .upd(done), .upd_addr(m_addr),
        .upd_half(m_half), .upd_flags(pkt.exc_on), .upd_ns(pkt.ns),
        .upd_alt(pkt.alt), .sync_load(sync_load), .sync_addr(sync_addr),
        .sync_half(sync_half), .sync_ns(sync_ns), .sync_alt(sync_alt),
        .ctx_addr(ctx_addr), .ctx_half(ctx_half), .ctx_ns(ctx_ns),
        .ctx_alt(ctx_alt)
    );

    // Ready rises one cycle after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    // Record and error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid <= 1'b0; rec_addr <= '0; rec_half <= 1'b0; rec_exc <= '0;
            rec_ns <= 1'b0; rec_alt <= 1'b0; rec_hyp <= 1'b0; rec_exec <= 1'b0;
            rec_cnt <= '0; rec_cnt_vld <= 1'b0; proto_err <= 1'b0;
        end else begin
            rec_valid <= done;
            proto_err <= err;
            if (done) begin
                rec_addr    <= m_addr;
                rec_half    <= m_half;
                rec_exc     <= pkt.exc;
                rec_ns      <= pkt.exc_on ? pkt.ns  : ctx_ns;
                rec_alt     <= pkt.exc_on ? pkt.alt : ctx_alt;
                rec_hyp     <= pkt.hyp;
                rec_exec    <= (pkt.exc == '0);
                rec_cnt     <= pkt.cnt;
                rec_cnt_vld <= pkt.cnt_on;
            end
        end
    end

    // R3
    rec_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> $past(in_valid && in_ready));
    // R8
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rec_valid && proto_err));
    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(in_byte[7] && in_valid));
    // R4
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_addr[0] == 1'b0 && (rec_half || rec_addr[1] == 1'b0)));
endmodule

// File: tb/bpd_decoder_bench.sv
module bpd_decoder_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        in_valid = 1'b0, cyc_mode = 1'b0, sync_load = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [31:0] sync_addr = 32'h0;
    logic        sync_half = 1'b0, sync_ns = 1'b0, sync_alt = 1'b0;
    logic        in_ready, rec_valid, rec_half, rec_ns, rec_alt, rec_hyp;
    logic        rec_exec, rec_cnt_vld, proto_err;
    logic [31:0] rec_addr, rec_cnt;
    logic [8:0]  rec_exc;

    int n_chk = 0, n_bad = 0;
    string scen = "R10";
    bit armed = 0, ended = 0;

    always #(CLK_P/2) clk = ~clk;

    bpd_decoder u_bpd_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .cyc_mode(cyc_mode), .sync_load(sync_load),
        .sync_addr(sync_addr), .sync_half(sync_half), .sync_ns(sync_ns),
        .sync_alt(sync_alt), .rec_valid(rec_valid), .rec_addr(rec_addr),
        .rec_half(rec_half), .rec_exc(rec_exc), .rec_ns(rec_ns),
        .rec_alt(rec_alt), .rec_hyp(rec_hyp), .rec_exec(rec_exec),
        .rec_cnt(rec_cnt), .rec_cnt_vld(rec_cnt_vld), .proto_err(proto_err)
    );

    // ---------------- reference model ----------------
    logic [7:0]  q[$];
    bit          m_cyc, m_ready;
    logic [31:0] m_addr;
    bit          m_half, m_ns, m_alt;
    bit          e_valid, e_err, e_half, e_ns, e_alt, e_hyp, e_exec, e_cv;
    logic [31:0] e_addr, e_cnt;
    logic [8:0]  e_exc;

    // Parse a whole queued packet; 0 = needs more, 1 = complete, 2 = error.
    function automatic int parse(input logic [7:0] b[$], input bit cyc,
        output logic [63:0] pay, output int nb, output bit b4, output bit half,
        output bit exon, output logic [8:0] exc, output bit ns, output bit alt,
        output bit hyp, output logic [63:0] cnt);
        int p = 0;
        bit follow = 0;
        logic [7:0] c;
        pay = 0; nb = 0; b4 = 0; half = 0; exon = 0; exc = 0; ns = 0; alt = 0;
        hyp = 0; cnt = 0;
        for (int k = 0; k < 5; k++) begin
            if (p >= b.size()) return 0;
            c = b[p]; p++;
            if (k == 0) begin
                pay = 64'(c[6:1]); nb = 6;
                if (!c[7]) break;
            end else if (k < 4) begin
                if (c[7]) begin pay |= 64'(c[6:0]) << nb; nb += 7; end
                else begin pay |= 64'(c[5:0]) << nb; nb += 6; follow = c[6]; break; end
            end else begin
                if (c[7]) return 2;
                b4 = 1; half = c[4]; follow = c[6];
                pay |= (half ? 64'(c[3:0]) : 64'(c[2:0])) << 27;
                nb = half ? 31 : 30;
            end
        end
        if (follow) begin
            if (p >= b.size()) return 0;
            c = b[p]; p++;
            exon = 1; ns = c[0]; exc[3:0] = c[4:1]; alt = c[5];
            if (c[7]) begin
                if (p >= b.size()) return 0;
                c = b[p]; p++;
                if (c[7]) return 2;
                exc[8:4] = c[4:0]; hyp = c[5];
            end
        end
        if (cyc) begin
            for (int k = 0; k < 5; k++) begin
                if (p >= b.size()) return 0;
                c = b[p]; p++;
                if (k == 0) cnt = 64'(c[3:0]);
                else cnt |= 64'(c[6:0]) << (4 + 7 * (k - 1));
                if (!c[7]) break;
                if (k == 4) return 2;
            end
        end
        return 1;
    endfunction

    always @(posedge clk) begin
        logic [63:0] pay, cnt, msk, a;
        int nb, st, sh;
        bit b4, hf, exon, ns, alt, hyp;
        logic [8:0] exc;
        armed <= 1;
        e_valid = 0; e_err = 0;
        if (!rst_n) begin
            q.delete(); m_ready = 0; m_addr = 0; m_half = 0; m_ns = 0; m_alt = 0;
            m_cyc = 0;
        end else begin
            if (in_valid && m_ready) begin
                if (q.size() == 0) m_cyc = cyc_mode;
                q.push_back(in_byte);
                st = parse(q, m_cyc, pay, nb, b4, hf, exon, exc, ns, alt, hyp, cnt);
                if (st == 2) begin e_err = 1; q.delete(); end
                else if (st == 1) begin
                    e_valid = 1;
                    e_half = b4 ? hf : m_half;
                    sh = e_half ? 1 : 2;
                    msk = ((64'd1 << nb) - 1) << sh;
                    a = (({32'h0, m_addr} & ~msk) | (pay << sh)) & 64'hFFFF_FFFF;
                    a = (a >> sh) << sh;
                    e_addr = a[31:0];
                    e_exc = exc; e_hyp = hyp; e_exec = (exc == 0);
                    e_ns = exon ? ns : m_ns; e_alt = exon ? alt : m_alt;
                    e_cnt = cnt[31:0]; e_cv = m_cyc;
                    m_addr = e_addr; m_half = e_half; m_ns = e_ns; m_alt = e_alt;
                    q.delete();
                end
            end
            if (sync_load) begin
                m_addr = sync_addr; m_half = sync_half; m_ns = sync_ns; m_alt = sync_alt;
            end
            m_ready = 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s [%s] actual=%h expected=%h", req, what, scen, act, exp);
        end
    endtask

    // Compare design against model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (armed && !ended) begin
            chk("R10", "in_ready", 64'(in_ready), 64'(m_ready));
            chk("R3", "rec_valid", 64'(rec_valid), 64'(e_valid));
            chk("R8", "proto_err", 64'(proto_err), 64'(e_err));
            if (e_valid && rec_valid) begin
                chk("R3", "rec_addr", 64'(rec_addr), 64'(e_addr));
                chk("R4", "rec_half", 64'(rec_half), 64'(e_half));
                chk("R5", "rec_exc", 64'(rec_exc), 64'(e_exc));
                chk("R5", "rec_hyp", 64'(rec_hyp), 64'(e_hyp));
                chk("R6", "rec_ns", 64'(rec_ns), 64'(e_ns));
                chk("R6", "rec_alt", 64'(rec_alt), 64'(e_alt));
                chk("R6", "rec_exec", 64'(rec_exec), 64'(e_exec));
                chk("R7", "rec_cnt", 64'(rec_cnt), 64'(e_cnt));
                chk("R7", "rec_cnt_vld", 64'(rec_cnt_vld), 64'(e_cv));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic put(input logic [7:0] b, input bit syn = 0);
        @(negedge clk);
        in_valid = 1; in_byte = b; sync_load = syn;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 0; sync_load = 0;
        end
    endtask

    task automatic do_sync(input logic [31:0] a, input bit h, input bit ns, input bit alt);
        sync_addr = a; sync_half = h; sync_ns = ns; sync_alt = alt;
        @(negedge clk);
        in_valid = 0; sync_load = 1;
        idle(1);
    endtask

    task automatic send_rand_pkt();
        logic [7:0] b[$];
        int na, ne, nc, cut;
        bit fol, cyc;
        logic [7:0] v;
        na = $urandom_range(1, 5);
        fol = (na > 1) ? bit'($urandom_range(0, 1)) : 1'b0;
        ne = fol ? $urandom_range(1, 2) : 0;
        cyc = bit'($urandom_range(0, 1));
        nc = cyc ? $urandom_range(1, 5) : 0;
        cut = -1;
        for (int k = 0; k < na; k++) begin
            v = 8'($urandom);
            v[7] = (k != na - 1);
            if (k == na - 1 && k > 0) v[6] = fol;
            if (k == 4 && $urandom_range(0, 7) == 0) begin v[7] = 1; cut = k; end
            b.push_back(v);
        end
        for (int k = 0; k < ne && cut < 0; k++) begin
            v = 8'($urandom);
            v[7] = (k != ne - 1);
            if (k == 1 && $urandom_range(0, 7) == 0) begin v[7] = 1; cut = na + k; end
            b.push_back(v);
        end
        for (int k = 0; k < nc && cut < 0; k++) begin
            v = 8'($urandom);
            v[7] = (k != nc - 1);
            if (k == 4 && $urandom_range(0, 7) == 0) begin v[7] = 1; cut = 0; end
            b.push_back(v);
        end
        for (int i = 0; i < b.size(); i++) begin
            if (i == 0) cyc_mode = cyc;
            else cyc_mode = bit'($urandom_range(0, 1));
            if (i == b.size() - 1 && $urandom_range(0, 5) == 0) begin
                sync_addr = $urandom; sync_half = bit'($urandom_range(0, 1));
                sync_ns = bit'($urandom_range(0, 1)); sync_alt = bit'($urandom_range(0, 1));
                put(b[i], 1);
            end else put(b[i]);
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 2));
        end
        idle($urandom_range(1, 2));
    endtask

    task automatic report();
        ended = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(7));
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle(2);

        scen = "R9 sync load";
        do_sync(32'h1234_5678, 1, 0, 0);
        scen = "R1 one byte";
        put(8'h2A); idle(1);
        n_chk++;
        if (rec_addr !== 32'h1234_562A) begin
            n_bad++; $display("FAIL R1 addr actual=%h expected=%h", rec_addr, 32'h1234_562A);
        end
        idle(1);
        scen = "R1 two bytes";
        put(8'h81); put(8'h05); idle(2);
        scen = "R2 R5 exception byte";
        put(8'h83); put(8'h47); put(8'h3F); idle(2);
        scen = "R5 two exception bytes hyp";
        put(8'hC1); put(8'h51); put(8'h9A); put(8'h23); idle(2);
        scen = "R4 switch to word";
        put(8'hFF); put(8'hFF); put(8'h80); put(8'h81); put(8'h05); idle(2);
        scen = "R4 R6 switch to half, zero exception";
        put(8'h91); put(8'h80); put(8'h80); put(8'h80); put(8'h5A); put(8'h00); idle(2);
        scen = "R6 no exception keeps flags";
        put(8'h06); idle(2);
        scen = "R7 counts";
        cyc_mode = 1;
        put(8'h04); put(8'h05); idle(2);
        put(8'h04); put(8'h00); idle(2);
        put(8'h82); put(8'h10); put(8'h8F); put(8'hFF); put(8'h01); idle(2);
        put(8'h04); put(8'hFF); put(8'hFF); put(8'hFF); put(8'hFF); put(8'h7F); idle(2);
        scen = "R8 count overflow";
        put(8'h04); put(8'h81); put(8'h81); put(8'h81); put(8'h81); put(8'h81); idle(2);
        cyc_mode = 0;
        scen = "R8 address overflow";
        put(8'h81); put(8'h80); put(8'h80); put(8'h80); put(8'h80); idle(1);
        put(8'h08); idle(2);
        scen = "R8 exception overflow";
        put(8'h83); put(8'h41); put(8'h81); put(8'h80); idle(1);
        put(8'h0A); idle(2);
        scen = "R9 sync with last byte";
        sync_addr = 32'hCAFE_0000; sync_half = 0; sync_ns = 1; sync_alt = 1;
        put(8'h81); put(8'h01, 1); idle(2);
        put(8'h7E); idle(2);
        scen = "R9 sync mid packet";
        sync_addr = 32'h0BAD_F00C; sync_half = 1;
        put(8'h81, 1); put(8'h02); idle(2);

        scen = "random";
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 15) == 0)
                do_sync($urandom, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                        bit'($urandom_range(0, 1)));
            send_rand_pkt();
        end
        idle(3);
        report();
    end
endmodule